// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

After reset, this block reads a 32-word image from a four-wire serial EEPROM into local storage. It needs no host action to do so. The first read also serves as a presence probe. If no device answers, the load stops and every loaded output stays at zero. Once the full image is in, four integrity tests run over it:

- a hardware identifier byte,
- a 16-bit partial checksum over selected bytes,
- a signature byte pair,
- an 8-bit sum over all 64 bytes.

A single-cycle done strobe then reports the outcome. A configuration-valid strobe fires with it only when every test passes.

The loaded image is exposed in two parts: a 48-bit station address and the configuration word images held in words 8 to 31. The address is shown even when a test fails, so that it can be inspected. After the load, a host may write a single word back through the same serial wires.

The serial clock comes from the system clock through a divider. Each half period lasts `SCLK_DIV` system cycles.

Top module: `cfg_eeprom_loader`

## Requirements
- R1: After reset, the block reads word addresses 0 to 31 in ascending order without any host action. Each read starts with a 1 start bit, then opcode `10`, then the 6-bit address MSB first. `ee_do` is valid at each rising `ee_sk`. `ee_cs` goes low between words.
- R2: After the address, the device returns one dummy bit and then 16 data bits MSB first. All of them are sampled on rising `ee_sk`. Word w holds byte 2w in bits [7:0] and byte 2w+1 in bits [15:8].
- R3: If the dummy bit of the read of word 0 is high, the device is absent. No further reads follow. `load_done` pulses with `dev_present`=0, `cfg_valid`=0 and `chk_fail`=0, and all loaded outputs stay zero.
- R4: `station_addr` bits [8k+7:8k] hold image byte k, for k from 0 to 5.
- R5: `cfg_words` bits [16i+15:16i] hold image word 8+i, for i from 0 to 23.
- R6: `chk_fail[0]` is set when byte 08h is not 11h.
- R7: `chk_fail[1]` is set when word 6 (byte 0Dh high, byte 0Ch low) differs from the 16-bit sum of bytes 00h–0Bh, 0Eh and 0Fh.
- R8: `chk_fail[2]` is set when byte 0Eh or byte 0Fh is not 57h.
- R9: `chk_fail[3]` is set when the 8-bit sum of all 64 bytes is not FFh.
- R10: `load_done` pulses for one cycle per reset, after the last word is read. `cfg_valid` pulses in the same cycle only if `chk_fail` is all zero. Neither pulse repeats.
- R11: When `wr_busy` is low, a `wr_req` sends a 1 start bit, opcode `01`, the 6-bit address and 16 data bits, each field MSB first, and then drops `ee_cs`. `wr_busy` is high from the next cycle until the transfer ends.
- R12: A `wr_req` while `wr_busy` is high is ignored: no serial transfer results.
- R13: Each `ee_sk` half period inside a transfer is `SCLK_DIV` system cycles, and `ee_sk` is low whenever `ee_cs` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; starts a new load |
| ee_cs | output | 1 | Serial device select |
| ee_sk | output | 1 | Serial clock |
| ee_do | output | 1 | Serial data to the device |
| ee_di | input | 1 | Serial data from the device, pulled high when idle |
| wr_req | input | 1 | Request to write one word |
| wr_addr | input | 6 | Word address of the write |
| wr_data | input | 16 | Word to write |
| wr_busy | output | 1 | Load or write in progress |
| dev_present | output | 1 | Device answered the first read |
| load_done | output | 1 | One-cycle end-of-load strobe |
| cfg_valid | output | 1 | One-cycle strobe: image passed all tests |
| chk_fail | output | 4 | Failed tests: bit0 identifier, bit1 partial sum, bit2 signature, bit3 full sum |
| station_addr | output | 48 | Bytes 0..5 of the image |
| cfg_words | output | 384 | Image words 8..31 |

## Verification
Each read takes 26 serial bits of 2·`SCLK_DIV` cycles each, with one tick-aligned gap between words. The image is therefore complete about 32·(52·`SCLK_DIV`+`SCLK_DIV`) cycles after reset. `load_done`, `cfg_valid` and `chk_fail` all change on the cycle after the last word is captured. The bench does not predict that cycle. It waits for `load_done` on falling edges and checks every result on that same falling edge. It then checks on the next falling edge that the strobe has gone. Serial transfers are compared by a monitor when `ee_cs` falls, and `ee_sk` edge spacing is measured against 8·`SCLK_DIV` ns. `wr_busy` is sampled one falling edge after a request is raised.

// File: rtl/cfgld_pkg.sv
`timescale 1ns/1ps
package cfgld_pkg;
  localparam int unsigned EE_WORDS  = 32;
  localparam int unsigned AW        = 6;
  localparam int unsigned WW        = 16;
  localparam int unsigned IMG_BITS  = EE_WORDS * WW;
  localparam int unsigned IMG_BYTES = IMG_BITS / 8;
  localparam int unsigned CFG_FIRST = 8;
  localparam int unsigned CFG_WORDS = EE_WORDS - CFG_FIRST;
  localparam int unsigned SUM_SPAN  = 12;
  localparam int unsigned CK_WORD   = 6;
  localparam int unsigned SIG_BYTE  = 14;
  localparam int unsigned HWID_BYTE = 8;
  localparam logic [7:0]  HWID_VAL  = 8'h11;
  localparam logic [7:0]  SIG_VAL   = 8'h57;
  localparam logic [7:0]  FULL_GOAL = 8'hFF;
  localparam logic [1:0]  OP_RD     = 2'b10;
  localparam logic [1:0]  OP_WR     = 2'b01;

  typedef logic [IMG_BITS-1:0] img_t;

  function automatic logic [7:0] img_byte(img_t im, int unsigned k);
    return im[8*k +: 8];
  endfunction

  function automatic logic [15:0] part_sum(img_t im);
    logic [15:0] s = '0;
    for (int unsigned k = 0; k < SUM_SPAN; k++) s = s + 16'(img_byte(im, k));
    s = s + 16'(img_byte(im, SIG_BYTE)) + 16'(img_byte(im, SIG_BYTE + 1));
    return s;
  endfunction

  function automatic logic [7:0] full_sum(img_t im);
    logic [7:0] s = '0;
    for (int unsigned k = 0; k < IMG_BYTES; k++) s = s + img_byte(im, k);
    return s;
  endfunction

  // bit0 identifier, bit1 partial sum, bit2 signature, bit3 full sum
  function automatic logic [3:0] judge(img_t im);
    logic [3:0] f;
    f[0] = img_byte(im, HWID_BYTE) != HWID_VAL;
    f[1] = part_sum(im) != im[CK_WORD*WW +: WW];
    f[2] = (img_byte(im, SIG_BYTE) != SIG_VAL) || (img_byte(im, SIG_BYTE + 1) != SIG_VAL);
    f[3] = full_sum(im) != FULL_GOAL;
    return f;
  endfunction
endpackage

// File: rtl/cfgld_tick.sv
`timescale 1ns/1ps
module cfgld_tick #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (cnt == LAST)  cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

  assign tick = (cnt == LAST);
endmodule

// File: rtl/cfgld_serial.sv
`timescale 1ns/1ps
module cfgld_serial
  import cfgld_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [WW-1:0] wdata,
  input  logic          di,
  output logic          done,
  output logic [WW-1:0] rdata,
  output logic          dummy,
  output logic          cs,
  output logic          sk,
  output logic          dout
);
  localparam int unsigned HDR  = 1 + 2 + AW;
  localparam int unsigned TXW  = HDR + WW;
  localparam int unsigned BIW  = $clog2(TXW + 2);
  localparam logic [BIW-1:0] DUMMY_IDX = BIW'(HDR);
  localparam logic [BIW-1:0] WR_LAST   = BIW'(TXW - 1);
  localparam logic [BIW-1:0] RD_LAST   = BIW'(TXW);

  logic           active, half, is_wr;
  logic [BIW-1:0] bidx;
  logic [TXW-1:0] tx;
  logic           rise_ev, last_ev;

  assign rise_ev = active && tick && !half;
  assign last_ev = active && tick && half && (bidx == (is_wr ? WR_LAST : RD_LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; half <= 1'b0; is_wr <= 1'b0; bidx <= '0; tx <= '0;
      cs <= 1'b0; sk <= 1'b0; done <= 1'b0; rdata <= '0; dummy <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !active) begin
        active <= 1'b1; cs <= 1'b1; sk <= 1'b0; half <= 1'b0; bidx <= '0; is_wr <= wr;
        tx <= {1'b1, (wr ? OP_WR : OP_RD), addr, (wr ? wdata : {WW{1'b0}})};
      end else if (rise_ev) begin
        sk   <= 1'b1;
        half <= 1'b1;
        if (bidx == DUMMY_IDX)     dummy <= di;
        else if (bidx > DUMMY_IDX) rdata <= {rdata[WW-2:0], di};
      end else if (last_ev) begin
        sk <= 1'b0; half <= 1'b0; active <= 1'b0; cs <= 1'b0; done <= 1'b1;
      end else if (active && tick) begin
        sk   <= 1'b0;
        half <= 1'b0;
        bidx <= bidx + 1'b1;
        tx   <= {tx[TXW-2:0], 1'b0};
      end
    end
  end

  assign dout = active & tx[TXW-1];

  AST_SK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !cs |-> !sk);  // R13
  AST_SK_ON_TICK:  assert property (@(posedge clk) disable iff (!rst_n) (active && !tick) |=> $stable(sk));  // R13
endmodule

// File: rtl/cfg_eeprom_loader.sv
`timescale 1ns/1ps
module cfg_eeprom_loader
  import cfgld_pkg::*;
#(
  parameter int unsigned SCLK_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  output logic                  ee_cs,
  output logic                  ee_sk,
  output logic                  ee_do,
  input  logic                  ee_di,
  input  logic                  wr_req,
  input  logic [AW-1:0]         wr_addr,
  input  logic [WW-1:0]         wr_data,
  output logic                  wr_busy,
  output logic                  dev_present,
  output logic                  load_done,
  output logic                  cfg_valid,
  output logic [3:0]            chk_fail,
  output logic [47:0]           station_addr,
  output logic [CFG_WORDS*WW-1:0] cfg_words
);
  localparam logic [AW-1:0] LAST_W = AW'(EE_WORDS - 1);

  typedef enum logic [2:0] {S_GAP, S_RD, S_CHK, S_IDLE, S_WR} st_t;

  st_t           st;
  logic [AW-1:0] widx;
  img_t          img;
  logic          tick, go, eng_done, dummy;
  logic [WW-1:0] rdata;
  logic [3:0]    fail_now;

  cfgld_tick #(.DIV(SCLK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick(tick));

  assign go = ((st == S_GAP) && tick) || ((st == S_IDLE) && wr_req);

  cfgld_serial u_ser (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go), .wr(st == S_IDLE),
    .addr((st == S_IDLE) ? wr_addr : widx), .wdata(wr_data), .di(ee_di),
    .done(eng_done), .rdata(rdata), .dummy(dummy),
    .cs(ee_cs), .sk(ee_sk), .dout(ee_do)
  );

  assign fail_now = judge(img);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_GAP; widx <= '0; img <= '0; dev_present <= 1'b0;
      load_done <= 1'b0; cfg_valid <= 1'b0; chk_fail <= '0;
    end else begin
      load_done <= 1'b0;
      cfg_valid <= 1'b0;
      unique case (st)
        S_GAP: if (tick) st <= S_RD;
        S_RD: if (eng_done) begin
          if ((widx == '0) && dummy) begin
            st <= S_IDLE; load_done <= 1'b1;
          end else begin
            dev_present <= 1'b1;
            img[widx*WW +: WW] <= rdata;
            if (widx == LAST_W) st <= S_CHK;
            else begin widx <= widx + 1'b1; st <= S_GAP; end
          end
        end
        S_CHK: begin
          chk_fail  <= fail_now;
          load_done <= 1'b1;
          cfg_valid <= (fail_now == 4'b0);
          st        <= S_IDLE;
        end
        S_IDLE: if (wr_req) st <= S_WR;
        S_WR:   if (eng_done) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign wr_busy      = (st != S_IDLE);
  assign station_addr = img[47:0];
  assign cfg_words    = img[IMG_BITS-1 : CFG_FIRST*WW];

  AST_VALID_CLEAN:  assert property (@(posedge clk) disable iff (!rst_n) cfg_valid |-> (load_done && chk_fail == 4'b0));  // R10
  AST_DONE_ONCE:    assert property (@(posedge clk) disable iff (!rst_n) load_done |=> !load_done);  // R10
  AST_IDLE_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) !wr_busy |-> !ee_cs);  // R11
  AST_ABSENT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n) (load_done && !dev_present) |-> (chk_fail == 4'b0 && !cfg_valid));  // R3
endmodule

// File: tb/cfg_eeprom_loader_test.sv
`timescale 1ns/1ps
module cfg_eeprom_loader_test;
  localparam int unsigned DIV = 4;
  localparam logic [1:0] RD = 2'b10;
  localparam logic [1:0] WR = 2'b01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic ee_cs, ee_sk, ee_do;
  logic ee_di = 1'b1;
  logic wr_req = 1'b0;
  logic [5:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic wr_busy, dev_present, load_done, cfg_valid;
  logic [3:0] chk_fail;
  logic [47:0] station_addr;
  logic [383:0] cfg_words;

  cfg_eeprom_loader #(.SCLK_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do), .ee_di(ee_di),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_busy(wr_busy),
    .dev_present(dev_present), .load_done(load_done), .cfg_valid(cfg_valid),
    .chk_fail(chk_fail), .station_addr(station_addr), .cfg_words(cfg_words)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct packed { logic [1:0] op; logic [5:0] addr; logic [15:0] data; } xfer_t;
  xfer_t expq[$];

  logic [7:0]  bb [64];
  logic [15:0] eemem [32];
  bit model_on = 1'b1;

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Scoreboard driver: queue the transfers the design owes.
  task automatic expect_xfer(logic [1:0] op, logic [5:0] addr, logic [15:0] data);
    expq.push_back({op, addr, data});
  endtask

  // EEPROM model and monitor
  logic pcs = 1'b0, psk = 1'b0;
  int bitcnt = 0;
  logic [31:0] cmd = '0;
  logic m_start;
  logic [1:0] m_op;
  logic [5:0] m_addr;
  bit have_prev = 1'b0;
  time prev_t = 0;

  task automatic edge_gap();
    if (have_prev) check("R13", "sk half period ns", 64'($time - prev_t), 64'(DIV * 8));
    have_prev = 1'b1;
    prev_t = $time;
  endtask

  task automatic end_xfer();
    xfer_t e;
    if (m_op == WR && bitcnt == 25) eemem[m_addr] = cmd[15:0];
    if (expq.size() == 0) begin
      check("R12", "unexpected transfer addr", 64'(m_addr), 64'hFFFF);
    end else begin
      e = expq.pop_front();
      if (e.op == WR) begin
        check("R11", "write start bit", 64'(m_start), 64'h1);
        check("R11", "write opcode", 64'(m_op), 64'(WR));
        check("R11", "write addr", 64'(m_addr), 64'(e.addr));
        check("R11", "write bits", 64'(bitcnt), 64'd25);
        check("R11", "write data", 64'(cmd[15:0]), 64'(e.data));
      end else begin
        check("R1", "read start bit", 64'(m_start), 64'h1);
        check("R1", "read opcode", 64'(m_op), 64'(RD));
        check("R1", "read addr", 64'(m_addr), 64'(e.addr));
        check("R2", "read bits", 64'(bitcnt), model_on ? 64'd26 : 64'd26);
      end
    end
  endtask

  always @(ee_cs or ee_sk) begin
    if (ee_cs && !pcs) begin
      bitcnt = 0; cmd = '0; ee_di = 1'b1; have_prev = 1'b0;
      check("R13", "sk low at select", 64'(ee_sk), 64'h0);
    end
    if (!ee_cs && pcs) end_xfer();
    if (ee_cs && ee_sk && !psk) begin
      cmd = {cmd[30:0], ee_do};
      bitcnt++;
      if (bitcnt == 9) begin m_start = cmd[8]; m_op = cmd[7:6]; m_addr = cmd[5:0]; end
      edge_gap();
    end
    if (ee_cs && !ee_sk && psk) begin
      edge_gap();
      if (model_on && bitcnt >= 9 && m_op == RD) begin
        if (bitcnt == 9) ee_di = 1'b0;
        else if (bitcnt <= 25) ee_di = eemem[m_addr][25 - bitcnt];
      end
    end
    pcs = ee_cs;
    psk = ee_sk;
  end

  // variant: 0 good, 1 bad id, 2 bad partial sum, 3 bad signature, 4 bad full sum
  task automatic build(int variant);
    logic [15:0] s;
    logic [7:0] t;
    for (int k = 0; k < 64; k++) bb[k] = 8'((k * 37 + variant * 11 + 5) & 8'hFF);
    bb[6] = 8'h00; bb[7] = 8'h00;
    bb[8] = (variant == 1) ? 8'h12 : 8'h11;
    bb[14] = 8'h57;
    bb[15] = (variant == 3) ? 8'h58 : 8'h57;
    s = '0;
    for (int k = 0; k < 12; k++) s = s + 16'(bb[k]);
    s = s + 16'(bb[14]) + 16'(bb[15]);
    if (variant == 2) s = s + 16'd1;
    bb[12] = s[7:0]; bb[13] = s[15:8];
    t = '0;
    for (int k = 0; k < 63; k++) t = t + bb[k];
    bb[63] = 8'hFF - t;
    if (variant == 4) bb[63] = bb[63] + 8'd1;
    for (int w = 0; w < 32; w++) eemem[w] = {bb[2*w+1], bb[2*w]};
  endtask

  task automatic run_load(int variant, bit present);
    logic [3:0] mask;
    int guard;
    mask = (variant == 0) ? 4'b0000 : 4'(1 << (variant - 1));
    build(variant);
    model_on = present;
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R10", "reset load_done", 64'(load_done), 64'h0);
    check("R10", "reset cfg_valid", 64'(cfg_valid), 64'h0);
    check("R13", "reset cs", 64'(ee_cs), 64'h0);
    check("R11", "reset busy", 64'(wr_busy), 64'h1);
    if (present) for (int w = 0; w < 32; w++) expect_xfer(RD, 6'(w), 16'h0);
    else expect_xfer(RD, 6'h0, 16'h0);
    rst_n = 1'b1;
    guard = 0;
    while (!load_done && guard < 20000) begin
      @(negedge clk);
      guard++;
      if (variant == 0 && present && guard == 300) begin
        wr_req = 1'b1; wr_addr = 6'h03; wr_data = 16'h1234;  // R12: during load
      end else wr_req = 1'b0;
    end
    wr_req = 1'b0;
    check("R10", "load_done seen", 64'(load_done), 64'h1);
    check("R3", "dev_present", 64'(dev_present), 64'(present));
    if (present) begin
      check(variant == 0 ? "R10" : (variant == 1 ? "R6" : variant == 2 ? "R7" : variant == 3 ? "R8" : "R9"),
            "chk_fail", 64'(chk_fail), 64'(mask));
      check("R10", "cfg_valid", 64'(cfg_valid), 64'(mask == 0));
      check("R4", "station_addr", 64'(station_addr),
            64'({bb[5], bb[4], bb[3], bb[2], bb[1], bb[0]}));
      for (int i = 0; i < 24; i++)
        check("R5", $sformatf("cfg word %0d", i + 8), 64'(cfg_words[16*i +: 16]), 64'({bb[2*i+17], bb[2*i+16]}));
    end else begin
      check("R3", "absent chk_fail", 64'(chk_fail), 64'h0);
      check("R3", "absent cfg_valid", 64'(cfg_valid), 64'h0);
      check("R3", "absent station", 64'(station_addr), 64'h0);
      check("R3", "absent cfg_words", 64'(cfg_words[63:0] | cfg_words[383:320]), 64'h0);
    end
    check("R1", "reads outstanding", 64'(expq.size()), 64'h0);
    @(negedge clk);
    check("R10", "load_done single pulse", 64'(load_done), 64'h0);
    check("R10", "cfg_valid single pulse", 64'(cfg_valid), 64'h0);
    check("R11", "idle after load", 64'(wr_busy), 64'h0);
    repeat (20 * DIV) @(negedge clk);
    check("R10", "no second strobe", 64'(load_done), 64'h0);
  endtask

  task automatic do_write(logic [5:0] a, logic [15:0] d);
    int guard;
    expect_xfer(WR, a, d);
    @(negedge clk);
    wr_req = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_req = 1'b0;
    check("R11", "busy after request", 64'(wr_busy), 64'h1);
    repeat (5) @(negedge clk);
    wr_req = 1'b1; wr_addr = a ^ 6'h3F; wr_data = ~d;  // R12: while busy
    @(negedge clk);
    wr_req = 1'b0;
    guard = 0;
    while (wr_busy && guard < 2000) begin @(negedge clk); guard++; end
    check("R11", "write finished", 64'(wr_busy), 64'h0);
    repeat (4 * DIV) @(negedge clk);
    check("R12", "transfers outstanding", 64'(expq.size()), 64'h0);
    check("R11", "device word written", 64'(eemem[a]), 64'(d));
  endtask

  initial begin
    run_load(0, 1'b1);
    do_write(6'h15, 16'hBEEF);
    do_write(6'h02, 16'h0A5C);
    run_load(1, 1'b1);
    run_load(2, 1'b1);
    run_load(3, 1'b1);
    run_load(4, 1'b1);
    run_load(0, 1'b0);
    repeat (10) @(negedge clk);
    finish_up();
  end

  initial begin
    #(8 * 190000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end
endmodule